// File: doc/BRIEF.md
# Manchester Word Transmitter for a Dual-Redundant Serial Bus

This block turns one 16-bit word per request into a 20-bit-time Manchester frame at 1 Mbit/s and drives it onto one of two redundant differential buses. A frame opens with a 3-bit-time sync pattern whose polarity marks the word as command/status or data. The 16 data bits follow MSB first, then an odd parity bit. The system clock may be 12, 16, 20 or 24 MHz. A two-bit select input picks the divider, and the frame takes the divider setting from the moment it starts.

One word can wait behind the frame on the line, so a stream of requests goes out with no idle gap. A watchdog counts bit cells of continuous transmission. When the count reaches the overrun limit, it shuts the transmitter down: both buses return to idle high and both inhibits rise. The shutdown stays until a clear pulse. Each finished frame is compared with the word the receive path decodes back. A mismatch, or no returned word within a grace window, raises a sticky loopback-fail flag. A stretch input keeps the line busy so that the shutdown path can be exercised.

Top module: `manchester_word_tx`

## Requirements
- R1: A frame is 40 half-bit cells. Each cell lasts DIV clock cycles, with DIV = 6, 8, 10, 12 for `clk_sel` = 0, 1, 2, 3 (12/16/20/24 MHz). `clk_sel` is taken when a frame starts.
- R2: Sync occupies cells 0..5. For `tx_is_data`=0 (command/status) the positive line is high for 3 cells and then low for 3. For `tx_is_data`=1 it is low for 3 and then high for 3.
- R3: Cells 6..37 carry the data bits, bit 15 first, two cells per bit. A 1 is high then low and a 0 is low then high. Cells 38..39 carry the parity bit in the same coding, chosen so that the 16 data bits plus parity hold an odd number of ones.
- R4: A bus that is not transmitting holds both its positive and negative lines high and holds its inhibit high.
- R5: `tx_bus_b`=0 sends on bus A and 1 sends on bus B. On the driven bus the negative line is the inverse of the positive line and the inhibit is low. The other bus stays idle per R4.
- R6: While a frame is on the line, `tx_ready` stays high until one further word is accepted, then goes low. A waiting word starts in the cell right after the previous parity cell, with no idle gap.
- R7: After OVR_HALVES continuous half-bit cells (default 1376, about 688 µs), `shutdown` goes high. Both buses return to idle with inhibits high, any waiting word is dropped and `tx_ready` is low. A run of 34 back-to-back frames (1360 cells) does not trip it.
- R8: `shutdown` stays high until `clear` is pulsed. `clear` also resets `lb_fail`.
- R9: While `stretch` is high the parity cells repeat indefinitely, so the frame never ends.
- R10: When the word returned on `lb_word`/`lb_is_data` with `lb_valid` differs in data or type from the last finished frame, `lb_fail` is set.
- R11: If no `lb_valid` arrives within LB_GRACE cycles (default 64) after a frame ends, `lb_fail` is set. A matching word arriving in time leaves it low.
- R12: After reset, `shutdown` and `lb_fail` are 0, `tx_ready` is 1 and both buses are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12/16/20/24 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Clock frequency code selecting the cell divider |
| tx_valid | input | 1 | Word request |
| tx_ready | output | 1 | Word can be accepted this cycle |
| tx_word | input | 16 | Word to send |
| tx_is_data | input | 1 | 1 = data sync, 0 = command/status sync |
| tx_bus_b | input | 1 | 1 = bus B, 0 = bus A |
| stretch | input | 1 | Test mode: hold the line past the overrun limit |
| clear | input | 1 | Clears shutdown and loopback-fail |
| lb_valid | input | 1 | Decoded loopback word strobe |
| lb_word | input | 16 | Decoded loopback word |
| lb_is_data | input | 1 | Decoded loopback word type |
| a_pos | output | 1 | Bus A positive line |
| a_neg | output | 1 | Bus A negative line |
| a_inh | output | 1 | Bus A transmitter inhibit |
| b_pos | output | 1 | Bus B positive line |
| b_neg | output | 1 | Bus B negative line |
| b_inh | output | 1 | Bus B transmitter inhibit |
| shutdown | output | 1 | Overrun shutdown flag |
| lb_fail | output | 1 | Loopback failure flag |

## Verification
The assertions check on every cycle the line rules and the flag rules:
- lines idle high when nothing is driven;
- complementary lines on the driven bus;
- no drive and both inhibits high during shutdown;
- the cell index stays in range;
- the watchdog count stays bounded;
- both flags stay set until clear.

Only the bench scenarios can show that each cell of a frame has the right level at the right time. The same holds for the gap-free chaining of queued words, the exact moment of shutdown under stretch, and the missing or wrong loopback words.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
  localparam int HALVES    = 40;
  localparam int HALF_W    = 6;
  localparam int DIV_W     = 4;

  typedef struct packed {
    logic [15:0] word;
    logic        is_data;
    logic        bus_b;
  } mwt_entry_t;

  function automatic logic [DIV_W-1:0] div_of(input logic [1:0] sel);
    return DIV_W'(6 + 2 * int'(sel));
  endfunction

  function automatic logic cell_level(input logic [15:0] w, input logic is_data,
                                      input logic [HALF_W-1:0] h);
    logic bitv;
    if (h < 6) begin
      return (h < 3) ? ~is_data : is_data;
    end
    if (h >= 38) bitv = ~^w;
    else         bitv = w[15 - ((h - 6) >> 1)];
    return h[0] ? ~bitv : bitv;
  endfunction
endpackage

// File: rtl/mwt_hold.sv
module mwt_hold
  import mwt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  mwt_entry_t load_val,
  input  logic       take,
  input  logic       flush,
  output logic       full,
  output mwt_entry_t entry
);
  logic       full_d;
  mwt_entry_t entry_d;
  logic       entry_en;

  always_comb begin
    full_d   = full;
    entry_en = 1'b0;
    entry_d  = load_val;
    if (flush)     full_d = 1'b0;
    else if (load) begin
      full_d   = 1'b1;
      entry_en = 1'b1;
    end else if (take) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        entry <= '0;
    else if (entry_en) entry <= entry_d;
  end

  assert_no_load_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && !flush) |=> full);
endmodule

// File: rtl/mwt_serializer.sv
module mwt_serializer
  import mwt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_sel,
  input  logic       hold_full,
  input  mwt_entry_t hold_entry,
  input  logic       stretch,
  input  logic       abort,
  output logic       take,
  output logic       active,
  output logic       level,
  output logic       half_tick,
  output logic       frame_done,
  output mwt_entry_t cur
);
  logic [DIV_W-1:0]  cnt_q, cnt_d, div_q, div_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic              active_d;
  mwt_entry_t        cur_d;

  assign active    = active_q_w;
  logic active_q_w;
  assign half_tick = active_q_w && (cnt_q == div_q - 1'b1);
  assign level     = cell_level(cur.word, cur.is_data, half_q);

  always_comb begin
    active_d   = active_q_w;
    cnt_d      = cnt_q;
    half_d     = half_q;
    div_d      = div_q;
    cur_d      = cur;
    take       = 1'b0;
    frame_done = 1'b0;
    if (abort) begin
      active_d = 1'b0;
      cnt_d    = '0;
      half_d   = '0;
    end else if (!active_q_w) begin
      if (hold_full) begin
        take     = 1'b1;
        active_d = 1'b1;
        cnt_d    = '0;
        half_d   = '0;
        cur_d    = hold_entry;
        div_d    = div_of(clk_sel);
      end
    end else if (half_tick) begin
      cnt_d = '0;
      if (half_q == HALF_W'(HALVES - 1)) begin
        if (stretch) begin
          half_d = HALF_W'(HALVES - 2);
        end else begin
          frame_done = 1'b1;
          half_d     = '0;
          if (hold_full) begin
            take  = 1'b1;
            cur_d = hold_entry;
            div_d = div_of(clk_sel);
          end else begin
            active_d = 1'b0;
          end
        end
      end else begin
        half_d = half_q + 1'b1;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q_w <= 1'b0;
      cnt_q      <= '0;
      half_q     <= '0;
      div_q      <= DIV_W'(6);
      cur        <= '0;
    end else begin
      active_q_w <= active_d;
      cnt_q      <= cnt_d;
      half_q     <= half_d;
      div_q      <= div_d;
      cur        <= cur_d;
    end
  end

  assert_half_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    half_q < HALF_W'(HALVES));
  assert_stretch_holds_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q_w && stretch && !abort) |=> active_q_w);
endmodule

// File: rtl/mwt_guard.sv
module mwt_guard
  import mwt_pkg::*;
#(
  parameter int OVR_HALVES = 1376,
  parameter int LB_GRACE   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic        half_tick,
  input  logic        clear,
  input  logic        frame_done,
  input  logic [15:0] sent_word,
  input  logic        sent_is_data,
  input  logic        lb_valid,
  input  logic [15:0] lb_word,
  input  logic        lb_is_data,
  output logic        shutdown,
  output logic        lb_fail
);
  localparam int WD_W = $clog2(OVR_HALVES + 1);
  localparam int GR_W = $clog2(LB_GRACE + 1);

  logic [WD_W-1:0] wd_q, wd_d;
  logic [GR_W-1:0] gr_q, gr_d;
  logic            shut_d, fail_d, await_q, await_d;
  logic [16:0]     exp_q, exp_d;

  always_comb begin
    wd_d   = wd_q;
    shut_d = shutdown;
    if (clear) shut_d = 1'b0;
    if (!active || clear) wd_d = '0;
    else if (half_tick) begin
      wd_d = wd_q + 1'b1;
      if (wd_q == WD_W'(OVR_HALVES - 1)) shut_d = 1'b1;
    end
  end

  always_comb begin
    await_d = await_q;
    exp_d   = exp_q;
    gr_d    = gr_q;
    fail_d  = lb_fail;
    if (frame_done) begin
      if (await_q) fail_d = 1'b1;
      await_d = 1'b1;
      exp_d   = {sent_is_data, sent_word};
      gr_d    = '0;
    end else if (await_q) begin
      if (lb_valid) begin
        if ({lb_is_data, lb_word} != exp_q) fail_d = 1'b1;
        await_d = 1'b0;
      end else if (gr_q == GR_W'(LB_GRACE - 1)) begin
        fail_d  = 1'b1;
        await_d = 1'b0;
      end else begin
        gr_d = gr_q + 1'b1;
      end
    end
    if (clear) fail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q     <= '0;
      shutdown <= 1'b0;
      await_q  <= 1'b0;
      exp_q    <= '0;
      gr_q     <= '0;
      lb_fail  <= 1'b0;
    end else begin
      wd_q     <= wd_d;
      shutdown <= shut_d;
      await_q  <= await_d;
      exp_q    <= exp_d;
      gr_q     <= gr_d;
      lb_fail  <= fail_d;
    end
  end

  assert_wd_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_q <= WD_W'(OVR_HALVES));
  assert_shutdown_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !clear) |=> shutdown);
  assert_lbfail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_fail && !clear) |=> lb_fail);
endmodule

// File: rtl/manchester_word_tx.sv
module manchester_word_tx
  import mwt_pkg::*;
#(
  parameter int OVR_HALVES = 1376,
  parameter int LB_GRACE   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  clk_sel,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [15:0] tx_word,
  input  logic        tx_is_data,
  input  logic        tx_bus_b,
  input  logic        stretch,
  input  logic        clear,
  input  logic        lb_valid,
  input  logic [15:0] lb_word,
  input  logic        lb_is_data,
  output logic        a_pos,
  output logic        a_neg,
  output logic        a_inh,
  output logic        b_pos,
  output logic        b_neg,
  output logic        b_inh,
  output logic        shutdown,
  output logic        lb_fail
);
  mwt_entry_t hold_e, cur_e, in_e;
  logic hold_full, take, active, level, half_tick, frame_done;
  logic drive_a, drive_b;

  assign in_e     = '{word: tx_word, is_data: tx_is_data, bus_b: tx_bus_b};
  assign tx_ready = !hold_full && !shutdown;

  mwt_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(tx_valid && tx_ready), .load_val(in_e),
    .take(take), .flush(shutdown), .full(hold_full), .entry(hold_e)
  );

  mwt_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .hold_full(hold_full),
    .hold_entry(hold_e), .stretch(stretch), .abort(shutdown), .take(take),
    .active(active), .level(level), .half_tick(half_tick),
    .frame_done(frame_done), .cur(cur_e)
  );

  mwt_guard #(.OVR_HALVES(OVR_HALVES), .LB_GRACE(LB_GRACE)) u_guard (
    .clk(clk), .rst_n(rst_n), .active(active), .half_tick(half_tick),
    .clear(clear), .frame_done(frame_done), .sent_word(cur_e.word),
    .sent_is_data(cur_e.is_data), .lb_valid(lb_valid), .lb_word(lb_word),
    .lb_is_data(lb_is_data), .shutdown(shutdown), .lb_fail(lb_fail)
  );

  assign drive_a = active && !shutdown && !cur_e.bus_b;
  assign drive_b = active && !shutdown &&  cur_e.bus_b;
  assign a_pos = drive_a ? level  : 1'b1;
  assign a_neg = drive_a ? ~level : 1'b1;
  assign a_inh = !drive_a;
  assign b_pos = drive_b ? level  : 1'b1;
  assign b_neg = drive_b ? ~level : 1'b1;
  assign b_inh = !drive_b;

  assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    a_inh |-> (a_pos && a_neg));
  assert_idle_high_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    b_inh |-> (b_pos && b_neg));
  assert_one_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_inh || b_inh) && (a_inh || (a_pos != a_neg)) && (b_inh || (b_pos != b_neg)));
  assert_shutdown_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (a_inh && b_inh && !tx_ready));
endmodule

// File: tb/manchester_word_tx_test.sv
module manchester_word_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic tx_valid = 1'b0, tx_is_data = 1'b0, tx_bus_b = 1'b0;
  logic [15:0] tx_word = '0, lb_word = '0;
  logic stretch = 1'b0, clear = 1'b0, lb_valid = 1'b0, lb_is_data = 1'b0;
  logic tx_ready, a_pos, a_neg, a_inh, b_pos, b_neg, b_inh, shutdown, lb_fail;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  manchester_word_tx uut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_word(tx_word), .tx_is_data(tx_is_data),
    .tx_bus_b(tx_bus_b), .stretch(stretch), .clear(clear), .lb_valid(lb_valid),
    .lb_word(lb_word), .lb_is_data(lb_is_data), .a_pos(a_pos), .a_neg(a_neg),
    .a_inh(a_inh), .b_pos(b_pos), .b_neg(b_neg), .b_inh(b_inh),
    .shutdown(shutdown), .lb_fail(lb_fail)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_cell(input logic [15:0] w, input bit d, input int h);
    bit b;
    if (h < 6) return (h < 3) ? !d : d;
    b = (h >= 38) ? !(^w) : w[15 - (h - 6) / 2];
    return (h % 2) ? !b : b;
  endfunction

  function automatic int div_for(input logic [1:0] s);
    return 6 + 2 * s;
  endfunction

  task automatic send(input logic [15:0] w, input bit d, input bit bb);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_word = w; tx_is_data = d; tx_bus_b = bb;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_start(input bit bb);
    int n = 0;
    while ((bb ? (b_pos && b_neg) : (a_pos && a_neg)) && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  // R1 R2 R3 R5: cell-by-cell check of one frame
  task automatic check_frame(input logic [15:0] w, input bit d, input bit bb,
                             input int dv, input bit first);
    int bad = 0, first_bad = -1;
    bit lv;
    for (int h = 0; h < 40; h++) begin
      if (h == 0 && first) begin
        wait_start(bb);
        repeat (dv / 2) @(negedge clk);
      end else begin
        repeat (dv) @(negedge clk);
      end
      lv = exp_cell(w, d, h);
      if (bb) begin
        if (b_pos !== lv || b_neg !== !lv || b_inh !== 1'b0 ||
            !(a_pos && a_neg && a_inh)) begin bad++; if (first_bad < 0) first_bad = h; end
      end else begin
        if (a_pos !== lv || a_neg !== !lv || a_inh !== 1'b0 ||
            !(b_pos && b_neg && b_inh)) begin bad++; if (first_bad < 0) first_bad = h; end
      end
    end
    check(bad == 0, $sformatf("R1/R2/R3/R5 frame w=%h d=%0d bus=%0d first bad cell", w, d, bb),
          first_bad, -1);
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1; @(negedge clk); clear = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1553));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 and R4: reset state
    check(tx_ready && !shutdown && !lb_fail, "R12 reset flags", {tx_ready, shutdown, lb_fail}, 4);
    check(a_pos && a_neg && a_inh && b_pos && b_neg && b_inh, "R4 idle lines",
          {a_pos, a_neg, a_inh, b_pos, b_neg, b_inh}, 63);

    // directed corners: all ones, all zeros, both types, both buses, all dividers
    for (int i = 0; i < 4; i++) begin
      logic [15:0] w = (i == 0) ? 16'hFFFF : (i == 1) ? 16'h0000 : (i == 2) ? 16'h8001 : 16'h7FFE;
      clk_sel = 2'(i);
      fork
        send(w, i[0], i[1]);
        check_frame(w, i[0], i[1], div_for(2'(i)), 1'b1);
      join
      repeat (div_for(2'(i)) / 2 + 3) @(negedge clk);
      lb_valid = 1'b1; lb_word = w; lb_is_data = i[0];
      @(negedge clk); lb_valid = 1'b0;
      repeat (80) @(negedge clk);
      check(!lb_fail, "R11 matching loopback keeps lb_fail low", lb_fail, 0);
      check(a_inh && b_inh && a_pos && a_neg && b_pos && b_neg, "R4 idle after frame", a_inh, 1);
    end

    // constrained random frames with correct loopback
    for (int i = 0; i < 10; i++) begin
      logic [15:0] w = 16'($urandom);
      bit d = 1'($urandom), bb = 1'($urandom);
      logic [1:0] s = 2'($urandom);
      clk_sel = s;
      fork
        send(w, d, bb);
        check_frame(w, d, bb, div_for(s), 1'b1);
      join
      repeat (div_for(s) / 2 + 2) @(negedge clk);
      lb_valid = 1'b1; lb_word = w; lb_is_data = d;
      @(negedge clk); lb_valid = 1'b0;
      repeat (70) @(negedge clk);
      check(!lb_fail, "R10 random matching loopback", lb_fail, 0);
    end

    // R10: wrong data and wrong type
    for (int k = 0; k < 2; k++) begin
      clk_sel = 2'd0;
      fork
        send(16'h1234, 1'b0, 1'b0);
        check_frame(16'h1234, 1'b0, 1'b0, 6, 1'b1);
      join
      repeat (5) @(negedge clk);
      lb_valid = 1'b1; lb_word = (k == 0) ? 16'h1235 : 16'h1234; lb_is_data = (k == 1);
      @(negedge clk); lb_valid = 1'b0;
      @(negedge clk);
      check(lb_fail, "R10 mismatched loopback sets lb_fail", lb_fail, 1);
      pulse_clear();
      check(!lb_fail, "R8 clear resets lb_fail", lb_fail, 0);
    end

    // R11: missing loopback
    fork
      send(16'hA5A5, 1'b1, 1'b1);
      check_frame(16'hA5A5, 1'b1, 1'b1, 6, 1'b1);
    join
    repeat (40) @(negedge clk);
    check(!lb_fail, "R11 no fail inside grace", lb_fail, 0);
    repeat (40) @(negedge clk);
    check(lb_fail, "R11 missing loopback sets lb_fail", lb_fail, 1);
    pulse_clear();

    // R6: three back-to-back words, no gap, ready drops when slot full
    clk_sel = 2'd1;
    fork
      begin
        send(16'h0F0F, 1'b0, 1'b0);
        send(16'hF00F, 1'b1, 1'b0);
        check(!tx_ready, "R6 ready low with waiting word", tx_ready, 0);
        send(16'h3C3C, 1'b1, 1'b0);
      end
      begin
        check_frame(16'h0F0F, 1'b0, 1'b0, 8, 1'b1);
        check_frame(16'hF00F, 1'b1, 1'b0, 8, 1'b0);
        check_frame(16'h3C3C, 1'b1, 1'b0, 8, 1'b0);
      end
    join
    repeat (100) @(negedge clk);
    pulse_clear();

    // R7: 34 chained frames stay below the limit
    clk_sel = 2'd0;
    for (int i = 0; i < 34; i++) send(16'(i * 977), 1'(i), 1'b0);
    repeat (600) @(negedge clk);
    check(!shutdown, "R7 34 chained frames no shutdown", shutdown, 0);
    pulse_clear();

    // R9 R7 R8: stretch drives shutdown at the limit
    stretch = 1'b1;
    fork
      send(16'h5555, 1'b0, 1'b1);
      wait_start(1'b1);
    join
    repeat (1376 * 6 - 12) @(negedge clk);
    check(!shutdown && !b_inh, "R9 stretched frame still on line", {shutdown, b_inh}, 0);
    repeat (20) @(negedge clk);
    check(shutdown, "R7 shutdown at overrun limit", shutdown, 1);
    check(a_inh && b_inh && b_pos && b_neg && !tx_ready, "R7 lines quiet in shutdown",
          {a_inh, b_inh, b_pos, b_neg, tx_ready}, 30);
    stretch = 1'b0;
    @(negedge clk); tx_valid = 1'b1; tx_word = 16'h1111;
    repeat (50) @(negedge clk);
    tx_valid = 1'b0;
    check(shutdown && b_inh && a_inh && a_pos && b_pos, "R8 shutdown held, request ignored",
          shutdown, 1);
    pulse_clear();
    check(!shutdown && tx_ready, "R8 clear releases shutdown", {shutdown, tx_ready}, 1);
    repeat (20) @(negedge clk);
    check(a_inh && b_inh, "R7 waiting word dropped, bus idle", {a_inh, b_inh}, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule